// File: doc/BRIEF.md
# Pipeline Hazard Interlock

This block is the interlock for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) that has no result bypassing. It looks at the instruction word sitting in the decode stage and works out which registers that instruction will read. It then compares those registers with the destination registers of the two older instructions still in execute and memory. If any used source matches a pending destination, the decode stage is frozen and a bubble is sent into execute until the producer reaches write-back.

Each pipe register takes a two-bit command: load its input, keep its value, or clear to all zeros. An all-zero stage is a no-op. The register file writes early in the cycle and reads late, so the write-back stage is never compared. The block also contains the pipe registers for the decode instruction word and for the destination tags of the later stages. This lets the surrounding datapath, and the bench, see the full interlock behaviour at the ports.

Top module: `hazard_interlock`

## Requirements
- R1: While reset is low, every stage holds all zeros: the decode word is 0, no stage has a pending write, every command is Transfer (2'b00) and `fetchHold` is 0.
- R2: A word whose opcode field [31:26] is zero is a no-op: it reads no register and writes none. Any other word reads register [25:21] and writes register [4:0].
- R3: The second source [20:16] is read only when bit 12 is 0 (register form). When bit 12 is 1 (literal form), bits [20:16] belong to the literal and cause no stall.
- R4: Register 31 never causes a stall, whether it appears as a source or as a pending destination.
- R5: A stall is raised exactly when a used source equals the destination of a write-enabled instruction in execute or in memory.
- R6: Commands use Transfer = 2'b00, Stall = 2'b01, Bubble = 2'b10. On a stall the fetch/decode register gets Stall, the decode/execute register gets Bubble and `fetchHold` is 1. With no stall all four commands are Transfer. The execute/memory and memory/write-back registers always get Transfer.
- R7: A pipe register loads its input on Transfer, keeps its value on Stall and clears to zero on Bubble. A bubbled stage shows no pending write.
- R8: An instruction in write-back is never compared, so a producer three instructions ahead causes no stall.
- R9: A dependent instruction stays in decode until its producer reaches write-back. A gap of one instruction costs two stall cycles and a gap of two costs one. Chained dependencies add up.
- R10: Destination tags move from execute to memory to write-back by one stage per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchWord | input | 32 | Instruction word offered by the fetch stage |
| fetchHold | output | 1 | High when fetch must present the same word again |
| idWord | output | 32 | Instruction word held in decode |
| ifIdCmd | output | 2 | Command to the fetch/decode register |
| idExCmd | output | 2 | Command to the decode/execute register |
| exMemCmd | output | 2 | Command to the execute/memory register |
| memWbCmd | output | 2 | Command to the memory/write-back register |
| exDest | output | 5 | Destination register held in execute |
| exWe | output | 1 | Write enable held in execute |
| memDest | output | 5 | Destination register held in memory |
| memWe | output | 1 | Write enable held in memory |
| wbDest | output | 5 | Destination register held in write-back |
| wbWe | output | 1 | Write enable held in write-back |

## Verification
The bench builds the block with its default field layout: 32-bit words, 5-bit register numbers, register 31 as the never-stalling register, and the literal flag at bit 12. With these values every field can be set directly from the bench's instruction builder. The bench therefore reaches producer-to-consumer gaps of one, two and three, literal forms whose literal bits alias a pending destination, chained dependencies, and no-op words that sit between a producer and its consumer.

// File: rtl/hazard_pkg.sv
`timescale 1ns/1ps
package hazard_pkg;
  localparam int INSTR_W  = 32;
  localparam int REG_W    = 5;
  localparam int OPC_MSB  = 31;
  localparam int OPC_LSB  = 26;
  localparam int SRCA_MSB = 25;
  localparam int SRCA_LSB = 21;
  localparam int SRCB_MSB = 20;
  localparam int SRCB_LSB = 16;
  localparam int LIT_FLAG = 12;
  localparam int DST_MSB  = 4;
  localparam int DST_LSB  = 0;
  localparam int TAG_STAGES = 3;
  localparam int TAG_W    = REG_W + 1;
  localparam logic [REG_W-1:0] ZERO_REG = {REG_W{1'b1}};

  typedef enum logic [1:0] {
    CMD_XFER  = 2'b00,
    CMD_HOLD  = 2'b01,
    CMD_CLEAR = 2'b10
  } pipeCmd_e;

  typedef struct packed {
    logic             wr;
    logic [REG_W-1:0] dst;
  } dstTag_t;

  typedef struct packed {
    logic     pcHold;
    pipeCmd_e ifIdCmd;
    pipeCmd_e idExCmd;
    pipeCmd_e exMemCmd;
    pipeCmd_e memWbCmd;
  } stageCtl_t;
endpackage

// File: rtl/pipe_stage.sv
`timescale 1ns/1ps
module pipe_stage
  import hazard_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  pipeCmd_e     cmd,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= '0;
    end else begin
      case (cmd)
        CMD_XFER:  q <= d;
        CMD_CLEAR: q <= '0;
        default:   q <= q;
      endcase
    end
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    cmd != pipeCmd_e'(2'b11)); // R6
  AST_XFER_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    cmd == CMD_XFER |=> q == $past(d)); // R7
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    cmd == CMD_HOLD |=> $stable(q)); // R7
  AST_CLEAR_ZEROS: assert property (@(posedge clk) disable iff (!rstN)
    cmd == CMD_CLEAR |=> q == '0); // R7
endmodule

// File: rtl/hazard_ctrl.sv
`timescale 1ns/1ps
module hazard_ctrl
  import hazard_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  input  logic             useA,
  input  logic             useB,
  input  dstTag_t          exTag,
  input  dstTag_t          memTag,
  output stageCtl_t        ctl
);
  localparam int NSRC  = 2;
  localparam int NPEND = 2;

  logic [REG_W-1:0]        srcId   [NSRC];
  logic                    srcUsed [NSRC];
  dstTag_t                 pend    [NPEND];
  logic [NSRC*NPEND-1:0]   hit;
  logic                    hazard;

  assign srcId[0]   = srcA;
  assign srcId[1]   = srcB;
  assign srcUsed[0] = useA;
  assign srcUsed[1] = useB;
  assign pend[0]    = exTag;
  assign pend[1]    = memTag;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    for (genvar p = 0; p < NPEND; p++) begin : g_pend
      assign hit[s*NPEND+p] = srcUsed[s] && (srcId[s] != ZERO_REG) &&
                              pend[p].wr && (pend[p].dst == srcId[s]);
    end
  end

  assign hazard = |hit;

  always_comb begin
    ctl.pcHold   = hazard;
    ctl.ifIdCmd  = hazard ? CMD_HOLD  : CMD_XFER;
    ctl.idExCmd  = hazard ? CMD_CLEAR : CMD_XFER;
    ctl.exMemCmd = CMD_XFER;
    ctl.memWbCmd = CMD_XFER;
  end

  AST_PAIRED_CMDS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ifIdCmd == CMD_HOLD |-> (ctl.idExCmd == CMD_CLEAR && ctl.pcHold)); // R6
  AST_R31_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (srcA == ZERO_REG && srcB == ZERO_REG) |-> ctl.ifIdCmd == CMD_XFER); // R4
  AST_LIT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!useB && srcA == ZERO_REG) |-> !ctl.pcHold); // R3
endmodule

// File: rtl/hazard_datapath.sv
`timescale 1ns/1ps
module hazard_datapath
  import hazard_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] fetchWord,
  input  stageCtl_t          ctl,
  output logic [INSTR_W-1:0] idWord,
  output logic [REG_W-1:0]   srcA,
  output logic [REG_W-1:0]   srcB,
  output logic               useA,
  output logic               useB,
  output dstTag_t            exTag,
  output dstTag_t            memTag,
  output dstTag_t            wbTag
);
  logic    isOperate;
  dstTag_t idTag;
  dstTag_t tagIn  [TAG_STAGES];
  dstTag_t tagOut [TAG_STAGES];
  pipeCmd_e tagCmd [TAG_STAGES];

  pipe_stage #(.W(INSTR_W)) u_ifId (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (ctl.ifIdCmd),
    .d    (fetchWord),
    .q    (idWord)
  );

  assign isOperate = |idWord[OPC_MSB:OPC_LSB];
  assign srcA      = idWord[SRCA_MSB:SRCA_LSB];
  assign srcB      = idWord[SRCB_MSB:SRCB_LSB];
  assign useA      = isOperate;
  assign useB      = isOperate && !idWord[LIT_FLAG];
  assign idTag.wr  = isOperate;
  assign idTag.dst = idWord[DST_MSB:DST_LSB];

  assign tagCmd[0] = ctl.idExCmd;
  assign tagCmd[1] = ctl.exMemCmd;
  assign tagCmd[2] = ctl.memWbCmd;

  for (genvar i = 0; i < TAG_STAGES; i++) begin : g_tag
    if (i == 0) begin : g_head
      assign tagIn[i] = idTag;
    end else begin : g_body
      assign tagIn[i] = tagOut[i-1];
    end
    pipe_stage #(.W(TAG_W)) u_stage (
      .clk  (clk),
      .rstN (rstN),
      .cmd  (tagCmd[i]),
      .d    (tagIn[i]),
      .q    (tagOut[i])
    );
  end

  assign exTag  = tagOut[0];
  assign memTag = tagOut[1];
  assign wbTag  = tagOut[2];

  AST_BUBBLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.idExCmd == CMD_CLEAR |=> !exTag.wr); // R7
  AST_ID_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ifIdCmd == CMD_HOLD |=> $stable(idWord)); // R9
  AST_WB_FROM_MEM: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWbCmd == CMD_XFER |=> wbTag == $past(memTag)); // R10
endmodule

// File: rtl/hazard_interlock.sv
`timescale 1ns/1ps
module hazard_interlock
  import hazard_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] fetchWord,
  output logic               fetchHold,
  output logic [INSTR_W-1:0] idWord,
  output logic [1:0]         ifIdCmd,
  output logic [1:0]         idExCmd,
  output logic [1:0]         exMemCmd,
  output logic [1:0]         memWbCmd,
  output logic [REG_W-1:0]   exDest,
  output logic               exWe,
  output logic [REG_W-1:0]   memDest,
  output logic               memWe,
  output logic [REG_W-1:0]   wbDest,
  output logic               wbWe
);
  stageCtl_t        ctl;
  logic [REG_W-1:0] srcA;
  logic [REG_W-1:0] srcB;
  logic             useA;
  logic             useB;
  dstTag_t          exTag;
  dstTag_t          memTag;
  dstTag_t          wbTag;

  hazard_datapath u_path (
    .clk       (clk),
    .rstN      (rstN),
    .fetchWord (fetchWord),
    .ctl       (ctl),
    .idWord    (idWord),
    .srcA      (srcA),
    .srcB      (srcB),
    .useA      (useA),
    .useB      (useB),
    .exTag     (exTag),
    .memTag    (memTag),
    .wbTag     (wbTag)
  );

  hazard_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .srcA   (srcA),
    .srcB   (srcB),
    .useA   (useA),
    .useB   (useB),
    .exTag  (exTag),
    .memTag (memTag),
    .ctl    (ctl)
  );

  assign fetchHold = ctl.pcHold;
  assign ifIdCmd   = ctl.ifIdCmd;
  assign idExCmd   = ctl.idExCmd;
  assign exMemCmd  = ctl.exMemCmd;
  assign memWbCmd  = ctl.memWbCmd;
  assign exDest    = exTag.dst;
  assign exWe      = exTag.wr;
  assign memDest   = memTag.dst;
  assign memWe     = memTag.wr;
  assign wbDest    = wbTag.dst;
  assign wbWe      = wbTag.wr;
endmodule

// File: tb/hazard_interlock_bench.sv
`timescale 1ns/1ps
module hazard_interlock_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchWord = 32'h0;
  logic        fetchHold;
  logic [31:0] idWord;
  logic [1:0]  ifIdCmd, idExCmd, exMemCmd, memWbCmd;
  logic [4:0]  exDest, memDest, wbDest;
  logic        exWe, memWe, wbWe;

  always #10 clk = ~clk;

  hazard_interlock u_hazard_interlock (
    .clk(clk), .rstN(rstN), .fetchWord(fetchWord), .fetchHold(fetchHold),
    .idWord(idWord), .ifIdCmd(ifIdCmd), .idExCmd(idExCmd),
    .exMemCmd(exMemCmd), .memWbCmd(memWbCmd),
    .exDest(exDest), .exWe(exWe), .memDest(memDest), .memWe(memWe),
    .wbDest(wbDest), .wbWe(wbWe)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  logic [31:0] prog [16];
  int progLen;
  int pc;
  int stallCount;

  // behavioural reference state
  logic [31:0] mId;
  logic [4:0]  mExD, mMemD, mWbD;
  logic        mExW, mMemW, mWbW;

  function automatic logic [31:0] rr(int ra, int rb, int rc);
    return {6'h10, 5'(ra), 5'(rb), 3'b000, 1'b0, 7'h20, 5'(rc)};
  endfunction

  function automatic logic [31:0] ri(int ra, int lit, int rc);
    return {6'h10, 5'(ra), 8'(lit), 1'b1, 7'h20, 5'(rc)};
  endfunction

  function automatic logic [31:0] wordAt(int i);
    return (i < progLen) ? prog[i] : 32'h0;
  endfunction

  function automatic bit pendHit(logic [4:0] r);
    if (r == 5'd31) return 0;
    return (mExW && mExD == r) || (mMemW && mMemD == r);
  endfunction

  function automatic bit modelHazard();
    if (mId[31:26] == 6'd0) return 0;
    return pendHit(mId[25:21]) || (!mId[12] && pendHit(mId[20:16]));
  endfunction

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    bit h;
    h = modelHazard();
    chk(fetchHold == h, "R5", "fetchHold", fetchHold, h);
    chk(ifIdCmd == (h ? 2'b01 : 2'b00), "R6", "ifIdCmd", ifIdCmd, h ? 1 : 0);
    chk(idExCmd == (h ? 2'b10 : 2'b00), "R6", "idExCmd", idExCmd, h ? 2 : 0);
    chk(exMemCmd == 2'b00, "R6", "exMemCmd", exMemCmd, 0);
    chk(memWbCmd == 2'b00, "R6", "memWbCmd", memWbCmd, 0);
    chk(idWord == mId, "R9", "idWord", idWord, mId);
    chk({exWe, exDest} == {mExW, mExD}, "R7", "ex tag", {exWe, exDest}, {mExW, mExD});
    chk({memWe, memDest} == {mMemW, mMemD}, "R10", "mem tag", {memWe, memDest}, {mMemW, mMemD});
    chk({wbWe, wbDest} == {mWbW, mWbD}, "R10", "wb tag", {wbWe, wbDest}, {mWbW, mWbD});
  endtask

  task automatic resetDut();
    rstN = 1'b0;
    fetchWord = 32'h0;
    pc = 0;
    mId = 0; mExD = 0; mMemD = 0; mWbD = 0;
    mExW = 0; mMemW = 0; mWbW = 0;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk(idWord == 32'h0, "R1", "idWord in reset", idWord, 0);
    chk({exWe, memWe, wbWe} == 3'b000, "R1", "write enables in reset", {exWe, memWe, wbWe}, 0);
    chk({ifIdCmd, idExCmd, exMemCmd, memWbCmd} == 8'h00, "R1", "commands in reset",
        {ifIdCmd, idExCmd, exMemCmd, memWbCmd}, 0);
    chk(fetchHold == 1'b0, "R1", "fetchHold in reset", fetchHold, 0);
    rstN = 1'b1;
    fetchWord = wordAt(0);
  endtask

  task automatic runProg(string name, int expStalls, string req);
    resetDut();
    stallCount = 0;
    for (int cyc = 0; cyc < progLen + 8; cyc++) begin
      bit h;
      logic [31:0] nId;
      logic [4:0]  nExD;
      logic        nExW;
      compareAll();
      if (fetchHold) stallCount++;
      h = modelHazard();
      if (h) begin
        nId = mId; nExD = 5'd0; nExW = 1'b0;
      end else begin
        nId = fetchWord; nExD = mId[4:0]; nExW = (mId[31:26] != 6'd0);
      end
      @(posedge clk);
      #1;
      mWbD = mMemD; mWbW = mMemW;
      mMemD = mExD; mMemW = mExW;
      mExD = nExD;  mExW = nExW;
      mId = nId;
      if (!h) pc++;
      fetchWord = wordAt(pc);
      @(negedge clk);
    end
    chk(stallCount == expStalls, req, {name, " stall cycles"}, stallCount, expStalls);
  endtask

  initial begin
    // R5: independent instructions never stall
    prog[0] = rr(5, 6, 1); prog[1] = rr(7, 8, 2); prog[2] = rr(9, 10, 3); progLen = 3;
    runProg("independent", 0, "R5");
    // R9: gap of one costs two stalls
    prog[0] = rr(1, 3, 2); prog[1] = rr(2, 5, 4); progLen = 2;
    runProg("gap one", 2, "R9");
    // R9: gap of two costs one stall
    prog[0] = rr(1, 3, 2); prog[1] = rr(8, 9, 7); prog[2] = rr(2, 5, 4); progLen = 3;
    runProg("gap two", 1, "R9");
    // R3: literal bits alias r2 but are not a read
    prog[0] = rr(1, 3, 2); prog[1] = ri(6, 8'h10, 4); progLen = 2;
    runProg("literal alias", 0, "R3");
    // R3: register-form second source does stall
    prog[0] = rr(1, 3, 2); prog[1] = rr(6, 2, 4); progLen = 2;
    runProg("second source", 2, "R3");
    // R3: literal form still checks the first source
    prog[0] = rr(1, 3, 2); prog[1] = ri(2, 8'h00, 4); progLen = 2;
    runProg("literal first source", 2, "R3");
    // R4: register 31 never stalls
    prog[0] = rr(1, 3, 31); prog[1] = rr(31, 31, 4); progLen = 2;
    runProg("register 31", 0, "R4");
    // R8: producer in write-back is not compared
    prog[0] = rr(1, 3, 2); prog[1] = rr(8, 9, 7); prog[2] = rr(10, 11, 12);
    prog[3] = rr(2, 5, 4); progLen = 4;
    runProg("gap three", 0, "R8");
    // R2: no-op word reads nothing; later reader of r0 stalls once
    prog[0] = rr(1, 3, 0); prog[1] = 32'h0; prog[2] = rr(0, 0, 5); progLen = 3;
    runProg("no-op between", 1, "R2");
    // R9: chained dependencies accumulate
    prog[0] = rr(1, 3, 2); prog[1] = rr(2, 2, 3); prog[2] = rr(3, 1, 4); progLen = 3;
    runProg("chain", 4, "R9");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule